// File: doc/BRIEF.md
# Eight-Region Memory Protection Checker

This block screens every processor memory access against eight programmable address regions. It returns three results for the access: whether it must be aborted, whether it may be cached and whether its write may be buffered. Each region has a base address, a size code, an enable bit, a two-bit permission field and one cacheable and one bufferable bit. Where regions overlap, a fixed priority decides which one applies. The block holds no state. The register file that holds the descriptors, the cache and the bus sit outside it and simply wire their fields to its ports.

The block is purely combinational, so all three results are valid in the same cycle as the address. A caller uses the abort result to stop the external bus cycle before it starts. It uses the cacheable and bufferable results to steer a line fill or a posted write.

Top module: `mpu_region_checker`

## Requirements
- R1: When more than one enabled, matching region covers the address, the region with the highest index supplies the permission, cacheable and bufferable values. Region 7 has the highest priority and region 0 the lowest.
- R2: With protection on, an access that matches no region sets abort.
- R3: A size code c from 11 to 31 describes a region of 2^(c+1) bytes: code 11 is 4 KB and code 31 is the whole 4 GB. The address matches when its bits 31 down to c+1 equal the same bits of the base. The base port holds address bits 31:12, and base bits below c+1 are ignored.
- R4: A region whose enable bit is 0 never matches.
- R5: A region whose size code is below 11 never matches.
- R6: The permission code of the winning region is decoded as follows, and an access it refuses sets abort. Code 0 refuses every access. Code 1 allows privileged reads and writes and refuses user accesses. Code 2 allows privileged reads and writes and user reads, and refuses user writes. Code 3 allows every access.
- R7: The packing of the descriptor ports follows the region number n. The permission port carries region n in bits 2n+1:2n. The cacheable and bufferable ports carry region n in bit n. The base port carries region n in bits 20n+19:20n, and the size port carries it in bits 5n+4:5n.
- R8: With protection off, abort, cacheable and bufferable are all 0, whatever the address and the descriptors.
- R9: An aborted access reports cacheable and bufferable as 0. An allowed access reports the winning region's cacheable and bufferable bits.
- R10: All outputs follow their inputs within the same cycle. No clock or register lies between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 32 | Byte address of the access |
| is_write | input | 1 | 1 for a write, 0 for a read |
| is_priv | input | 1 | 1 for a privileged access, 0 for a user access |
| prot_en | input | 1 | Protection enable |
| rgn_base | input | 160 | Region bases, address bits 31:12, 20 bits per region |
| rgn_size | input | 40 | Region size codes, 5 bits per region |
| rgn_en | input | 8 | Region enable, one bit per region |
| perm_word | input | 16 | Permission codes, 2 bits per region |
| cache_bits | input | 8 | Cacheable flag per region |
| buf_bits | input | 8 | Bufferable flag per region |
| abort | output | 1 | Access refused |
| cacheable | output | 1 | Access may be cached |
| bufferable | output | 1 | Write may be buffered |

## Verification
The assertions watch properties that must hold in every evaluation. With protection off, nothing is aborted or flagged. An aborted access never reports cacheable or bufferable. A disabled region, or one with a too-small size code, never raises its hit line. The selected winner is at most one-hot, is one of the hits, and has no hit above it. Other points depend on specific address and descriptor combinations, and only the bench's sweeps can show them. These are the exact region boundaries for every size code, the base bits that are ignored, the permission decode for every mode and direction, and the priority among all enable patterns.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;

  typedef enum logic [1:0] {
    PERM_NONE      = 2'b00,
    PERM_PRIV_ONLY = 2'b01,
    PERM_USER_RO   = 2'b10,
    PERM_FULL      = 2'b11
  } perm_code_t;

  // Decide whether a permission code grants an access of the given kind.
  function automatic logic perm_grants(input logic [1:0] code,
                                       input logic priv,
                                       input logic wr);
    logic ok;
    case (perm_code_t'(code))
      PERM_NONE:      ok = 1'b0;
      PERM_PRIV_ONLY: ok = priv;
      PERM_USER_RO:   ok = priv | ~wr;
      default:        ok = 1'b1;
    endcase
    return ok;
  endfunction

  // Number of low address bits that lie inside a region of the given code.
  function automatic int span_log2(input logic [4:0] code);
    return int'(code) + 1;
  endfunction

endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match #(
  parameter int ADDR_W   = 32,
  parameter int BASE_LSB = 12,
  parameter int SIZE_W   = 5,
  parameter int MIN_CODE = 11
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [ADDR_W-BASE_LSB-1:0] base,
  input  logic [SIZE_W-1:0]          code,
  input  logic                       en,
  output logic                       hit
);
  import mpu_chk_pkg::*;

  localparam int BASE_W = ADDR_W - BASE_LSB;

  logic [ADDR_W:0]   low_ones;
  logic [ADDR_W-1:0] keep_mask;
  logic [ADDR_W-1:0] base_full;
  logic              code_legal;

  always_comb begin
    low_ones   = ({{ADDR_W{1'b0}}, 1'b1} << span_log2(code)) - 1'b1;
    keep_mask  = ~low_ones[ADDR_W-1:0];
    base_full  = {base, {BASE_LSB{1'b0}}};
    code_legal = (int'(code) >= MIN_CODE);
    hit        = en & code_legal &
                 ((addr & keep_mask) == (base_full & keep_mask));
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, BASE_W[0]};

endmodule

// File: rtl/mpu_prio_pick.sv
module mpu_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hit_vec,
  output logic [N-1:0]     win_onehot,
  output logic [IDX_W-1:0] win_idx,
  output logic             any_hit
);
  always_comb begin
    win_onehot = '0;
    win_idx    = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        win_onehot    = '0;
        win_onehot[i] = 1'b1;
        win_idx       = IDX_W'(i);
      end
    end
    any_hit = |hit_vec;
  end
endmodule

// File: rtl/mpu_attr_resolve.sv
module mpu_attr_resolve #(
  parameter int N      = 8,
  parameter int PERM_W = 2,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [IDX_W-1:0]    win_idx,
  input  logic                any_hit,
  input  logic [N*PERM_W-1:0] perm_word,
  input  logic [N-1:0]        cache_bits,
  input  logic [N-1:0]        buf_bits,
  input  logic                is_write,
  input  logic                is_priv,
  input  logic                prot_en,
  output logic                perm_ok,
  output logic                abort,
  output logic                cacheable,
  output logic                bufferable
);
  import mpu_chk_pkg::*;

  logic [PERM_W-1:0] win_perm;
  logic              win_c;
  logic              win_b;
  logic              allow;

  always_comb begin
    win_perm   = perm_word[win_idx*PERM_W +: PERM_W];
    win_c      = cache_bits[win_idx];
    win_b      = buf_bits[win_idx];
    perm_ok    = any_hit & perm_grants(win_perm, is_priv, is_write);
    allow      = prot_en & perm_ok;
    abort      = prot_en & ~perm_ok;
    cacheable  = allow & win_c;
    bufferable = allow & win_b;
  end
endmodule

// File: rtl/mpu_region_checker.sv
module mpu_region_checker #(
  parameter int N        = 8,
  parameter int ADDR_W   = 32,
  parameter int BASE_LSB = 12,
  parameter int SIZE_W   = 5,
  parameter int PERM_W   = 2,
  parameter int MIN_CODE = 11
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              is_write,
  input  logic                              is_priv,
  input  logic                              prot_en,
  input  logic [N*(ADDR_W-BASE_LSB)-1:0]    rgn_base,
  input  logic [N*SIZE_W-1:0]               rgn_size,
  input  logic [N-1:0]                      rgn_en,
  input  logic [N*PERM_W-1:0]               perm_word,
  input  logic [N-1:0]                      cache_bits,
  input  logic [N-1:0]                      buf_bits,
  output logic                              abort,
  output logic                              cacheable,
  output logic                              bufferable
);
  localparam int BASE_W = ADDR_W - BASE_LSB;
  localparam int IDX_W  = $clog2(N);

  logic [N-1:0]     hit_vec;
  logic [N-1:0]     win_onehot;
  logic [IDX_W-1:0] win_idx;
  logic             any_hit;
  logic             perm_ok;

  for (genvar g = 0; g < N; g++) begin : g_rgn
    mpu_region_match #(
      .ADDR_W  (ADDR_W),
      .BASE_LSB(BASE_LSB),
      .SIZE_W  (SIZE_W),
      .MIN_CODE(MIN_CODE)
    ) u_match (
      .addr(addr),
      .base(rgn_base[g*BASE_W +: BASE_W]),
      .code(rgn_size[g*SIZE_W +: SIZE_W]),
      .en  (rgn_en[g]),
      .hit (hit_vec[g])
    );
  end

  mpu_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .hit_vec   (hit_vec),
    .win_onehot(win_onehot),
    .win_idx   (win_idx),
    .any_hit   (any_hit)
  );

  mpu_attr_resolve #(.N(N), .PERM_W(PERM_W), .IDX_W(IDX_W)) u_attr (
    .win_idx   (win_idx),
    .any_hit   (any_hit),
    .perm_word (perm_word),
    .cache_bits(cache_bits),
    .buf_bits  (buf_bits),
    .is_write  (is_write),
    .is_priv   (is_priv),
    .prot_en   (prot_en),
    .perm_ok   (perm_ok),
    .abort     (abort),
    .cacheable (cacheable),
    .bufferable(bufferable)
  );

endmodule

// File: rtl/mpu_region_checker_sva.sv
module mpu_region_checker_sva #(
  parameter int N        = 8,
  parameter int SIZE_W   = 5,
  parameter int MIN_CODE = 11
) (
  input logic              prot_en,
  input logic              abort,
  input logic              cacheable,
  input logic              bufferable,
  input logic [N-1:0]      hit_vec,
  input logic [N-1:0]      win_onehot,
  input logic              any_hit,
  input logic              perm_ok,
  input logic [N*SIZE_W-1:0] rgn_size,
  input logic [N-1:0]      rgn_en
);
  always_comb begin
    // R8: protection off passes everything, unflagged
    assert_off_passes_R8: assert (prot_en || (!abort && !cacheable && !bufferable))
      else $error("R8 violated");
    // R9: aborted access carries no attributes
    assert_abort_no_attr_R9: assert (!abort || (!cacheable && !bufferable))
      else $error("R9 violated");
    // R2: no hit under protection aborts
    assert_miss_aborts_R2: assert (!(prot_en && !any_hit) || abort)
      else $error("R2 violated");
    // R1: winner is one-hot and drawn from the hits
    assert_win_onehot_R1: assert ($onehot0(win_onehot) && ((win_onehot & ~hit_vec) == '0)
                                  && (any_hit == (|win_onehot)))
      else $error("R1 violated");
    // R6: a refused winner under protection aborts
    assert_perm_abort_R6: assert (!(prot_en && !perm_ok) || abort)
      else $error("R6 violated");
    for (int i = 0; i < N; i++) begin
      // R1: no hit above the winner
      assert_win_highest_R1: assert (!win_onehot[i] || ((hit_vec >> (i + 1)) == '0))
        else $error("R1 priority violated");
      // R4: disabled region silent
      assert_dis_silent_R4: assert (rgn_en[i] || !hit_vec[i])
        else $error("R4 violated");
      // R5: undersized code silent
      assert_small_silent_R5: assert ((int'(rgn_size[i*SIZE_W +: SIZE_W]) >= MIN_CODE) || !hit_vec[i])
        else $error("R5 violated");
    end
  end
endmodule

bind mpu_region_checker mpu_region_checker_sva #(
  .N(N), .SIZE_W(SIZE_W), .MIN_CODE(MIN_CODE)
) u_sva (
  .prot_en   (prot_en),
  .abort     (abort),
  .cacheable (cacheable),
  .bufferable(bufferable),
  .hit_vec   (hit_vec),
  .win_onehot(win_onehot),
  .any_hit   (any_hit),
  .perm_ok   (perm_ok),
  .rgn_size  (rgn_size),
  .rgn_en    (rgn_en)
);

// File: tb/mpu_region_checker_test.sv
`timescale 1ns/1ps
module mpu_region_checker_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0]  addr;
  logic         is_write, is_priv, prot_en;
  logic [159:0] rgn_base;
  logic [39:0]  rgn_size;
  logic [7:0]   rgn_en;
  logic [15:0]  perm_word;
  logic [7:0]   cache_bits, buf_bits;
  logic         abort, cacheable, bufferable;

  logic [19:0] b_base [8];
  logic [4:0]  b_code [8];

  int vecs = 0;
  int errs = 0;

  mpu_region_checker uut (
    .addr(addr), .is_write(is_write), .is_priv(is_priv), .prot_en(prot_en),
    .rgn_base(rgn_base), .rgn_size(rgn_size), .rgn_en(rgn_en),
    .perm_word(perm_word), .cache_bits(cache_bits), .buf_bits(buf_bits),
    .abort(abort), .cacheable(cacheable), .bufferable(bufferable)
  );

  task automatic pack_regions();
    for (int r = 0; r < 8; r++) begin
      rgn_base[r*20 +: 20] = b_base[r];
      rgn_size[r*5 +: 5]   = b_code[r];
    end
  endtask

  // Independent model: shift-and-compare, highest matching index wins.
  task automatic model(output logic ea, output logic ec, output logic eb);
    int win;
    logic [63:0] a64, bb;
    logic [1:0] p;
    logic ok;
    win = -1;
    for (int r = 0; r < 8; r++) begin
      if (rgn_en[r] && b_code[r] >= 5'd11) begin
        a64 = {32'h0, addr};
        bb  = {32'h0, b_base[r], 12'h000};
        if ((a64 >> (b_code[r] + 1)) == (bb >> (b_code[r] + 1))) win = r;
      end
    end
    if (!prot_en) begin
      ea = 0; ec = 0; eb = 0;
    end else if (win < 0) begin
      ea = 1; ec = 0; eb = 0;
    end else begin
      p  = perm_word[2*win +: 2];
      ok = (p == 2'd3) || (p == 2'd2 && (is_priv || !is_write)) || (p == 2'd1 && is_priv);
      ea = !ok;
      ec = ok && cache_bits[win];
      eb = ok && buf_bits[win];
    end
  endtask

  task automatic check(input string tag);
    logic ea, ec, eb;
    pack_regions();
    #1;
    model(ea, ec, eb);
    vecs++;
    if ({abort, cacheable, bufferable} !== {ea, ec, eb}) begin
      errs++;
      $display("FAIL %s addr=%h actual a/c/b=%b%b%b expected=%b%b%b",
               tag, addr, abort, cacheable, bufferable, ea, ec, eb);
    end
    @(negedge clk);
  endtask

  task automatic clear_all();
    for (int r = 0; r < 8; r++) begin b_base[r] = '0; b_code[r] = '0; end
    rgn_en = '0; perm_word = '0; cache_bits = '0; buf_bits = '0;
    addr = '0; is_write = 0; is_priv = 0; prot_en = 0;
  endtask

  initial begin
    #(5.0 * 190000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    clear_all();
    @(negedge clk);
    check("R8 idle state");

    // R6 / R9: permission decode on a 4 GB region 0
    prot_en = 1; rgn_en = 8'h01; b_code[0] = 5'd31;
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 4; m++) begin
        perm_word = 16'(p); is_priv = m[1]; is_write = m[0];
        cache_bits = 8'h01; buf_bits = 8'h01; addr = 32'h1234_5678;
        check("R6 perm decode");
      end

    // R3 / R5: every size code, boundaries, ignored low base bits
    clear_all(); prot_en = 1; rgn_en = 8'h08; perm_word = 16'hFFFF;
    cache_bits = 8'h08; buf_bits = 8'h00;
    for (int c = 0; c < 32; c++) begin
      logic [31:0] a0, span;
      b_code[3] = 5'(c); b_base[3] = 20'hA5A5A;
      span = (c >= 31) ? 32'h0 : (32'h1 << (c + 1));
      a0 = (c >= 31) ? 32'h0 : ({b_base[3], 12'h0} & ~(span - 1));
      addr = a0;             check(c < 11 ? "R5 small code" : "R3 base edge");
      addr = a0 + span - 1;  check("R3 top edge");
      addr = a0 + span;      check("R3 past top");
      addr = a0 - 1;         check("R3 below base");
      is_write = 1; addr = a0 + 32'h800; check("R3 mid write"); is_write = 0;
    end

    // R1 / R4 / R7: every enable pattern of overlapping full-space regions
    clear_all(); prot_en = 1;
    for (int r = 0; r < 8; r++) b_code[r] = 5'd31;
    perm_word = 16'b11_10_01_11_00_11_10_11;
    cache_bits = 8'b1010_0110; buf_bits = 8'b0101_1100;
    for (int e = 0; e < 256; e++)
      for (int m = 0; m < 4; m++) begin
        rgn_en = 8'(e); is_priv = m[1]; is_write = m[0]; addr = 32'hC000_0000 + 32'(e);
        check(e == 0 ? "R2 no region" : "R1 priority");
      end

    // R4: disabled region beside enabled, nested regions
    clear_all(); prot_en = 1; perm_word = 16'hFFFF; cache_bits = 8'hFF;
    b_code[6] = 5'd13; b_base[6] = 20'h00010; b_code[2] = 5'd20; b_base[2] = 20'h00000;
    rgn_en = 8'b0000_0100;
    addr = 32'h0001_0004; check("R4 disabled inner");
    rgn_en = 8'b0100_0100; cache_bits = 8'b0000_0100;
    addr = 32'h0001_0004; check("R1 inner wins");
    addr = 32'h0002_0000; check("R1 outer only");

    // R10 / R7: random configurations
    void'($urandom(32'd77));
    for (int k = 0; k < 3000; k++) begin
      for (int r = 0; r < 8; r++) begin
        b_base[r] = 20'($urandom);
        b_code[r] = 5'(9 + ($urandom % 23));
      end
      rgn_en = 8'($urandom); perm_word = 16'($urandom);
      cache_bits = 8'($urandom); buf_bits = 8'($urandom);
      is_write = 1'($urandom); is_priv = 1'($urandom);
      addr = (k % 2 == 0) ? {b_base[$urandom % 8], 12'($urandom)} : $urandom;
      prot_en = (k % 8 != 0);
      check(prot_en ? "R10 random" : "R8 off random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule